// File: doc/BRIEF.md
# Quad-Lane Sum of Absolute Differences Accumulator

This block collects sums of absolute pixel differences for block-matching motion estimation. On each valid cycle it takes two 64-bit pixel pairs. From each pair it cuts out a 4-byte window at a 2-bit byte offset, and each pair can have its two words exchanged first. The block then forms the absolute difference of the four byte lanes. Each lane's difference goes into its own unsigned 16-bit partial sum. The four partial sums sit as two halves in each of two 32-bit accumulators, and each one saturates. A loop over an 8x8 or 16x16 block issues one update per iteration.

When the loop ends, a reduce request folds each accumulator into a 32-bit total: the upper accumulator's two halves for one output and the lower accumulator's two halves for the other. The totals are registered. When an update arrives on the same edge as the reduce request, the totals already include it.

A two-state controller tracks whether the accumulators hold data. ST_EMPTY means every partial sum reads as zero, whatever the storage registers hold. ST_LIVE means the stored halves are current. The transitions are:
- reset_to_empty: reset enters ST_EMPTY.
- empty_to_live: a valid update takes ST_EMPTY to ST_LIVE.
- live_to_empty: a clear without a valid update takes ST_LIVE to ST_EMPTY.
- live_reload: clear and valid together keep ST_LIVE, with fresh values.
- idle_hold: with neither clear nor valid, the state stays where it is.

Top module: `sad_accum`

## Requirements
- R1: While rst_n is low, and on the first sample after it rises, sum_upper and sum_lower are zero, and every partial sum reads as zero.
- R2: Byte k of a pair is bits [8k+7:8k], with the lower word in bits [31:0]. An offset of o selects bytes o to o+3 as lanes 0 to 3.
- R3: When a swap input is high, the two 32-bit words of that pair trade places before the window is cut.
- R4: Lane 0 adds |a-b| into the lower accumulator's bits [15:0], and lane 1 into its bits [31:16]. Lane 2 adds into the upper accumulator's bits [15:0], and lane 3 into its bits [31:16].
- R5: A partial sum is unsigned, never decreases without a clear, and holds at 0xFFFF instead of wrapping.
- R6: clear with valid low sets all four partial sums to zero.
- R7: clear with valid high replaces the four partial sums with that cycle's differences.
- R8: A reduce request registers sum_upper = upper.lo + upper.hi and sum_lower = lower.lo + lower.hi, zero-extended to 32 bits. The values used are those after any update on the same edge.
- R9: With reduce low, sum_upper and sum_lower keep their values.
- R10: With valid and clear both low, the partial sums do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pair_a | input | 64 | First pixel pair, lower word in bits [31:0] |
| pair_b | input | 64 | Second pixel pair, lower word in bits [31:0] |
| off_a | input | 2 | Byte offset of the window in pair_a |
| off_b | input | 2 | Byte offset of the window in pair_b |
| swap_a | input | 1 | Exchange the words of pair_a before windowing |
| swap_b | input | 1 | Exchange the words of pair_b before windowing |
| valid | input | 1 | Accumulate this cycle's four differences |
| clear | input | 1 | Zero the partial sums; combines with valid as R7 states |
| reduce | input | 1 | Register the two folded totals |
| sum_upper | output | 32 | Upper accumulator, low half plus high half |
| sum_lower | output | 32 | Lower accumulator, low half plus high half |

## Verification
An update, a clear and a reduce request applied before a rising edge all take effect on that edge. The folded totals can be read from the ports one edge later. The bench drives inputs after a falling edge and lets the rising edge capture them. It advances its behavioural model with the same inputs at that edge and compares both outputs at the next falling edge, on every cycle. Partial sums have no port, so reduce requests in the directed cases expose them. Cycles with reduce low check that the totals hold.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int LANES = 4;
    localparam int PAIR_BYTES = 2 * LANES;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_LIVE  = 1'b1
    } sad_state_t;
endpackage

// File: rtl/sad_align.sv
module sad_align #(
    parameter int PIX_W = 8
) (
    input  logic [sad_pkg::PAIR_BYTES*PIX_W-1:0] pair,
    input  logic [1:0]                           offset,
    input  logic                                 swap,
    output logic [sad_pkg::LANES*PIX_W-1:0]      window
);
    localparam int WORD_W = sad_pkg::LANES * PIX_W;

    logic [2*WORD_W-1:0] ordered;

    assign ordered = swap ? {pair[WORD_W-1:0], pair[2*WORD_W-1:WORD_W]} : pair;

    for (genvar g = 0; g < sad_pkg::LANES; g++) begin : g_lane
        always_comb begin
            window[g*PIX_W +: PIX_W] = '0;
            for (int o = 0; o < 4; o++) begin
                if (offset == 2'(o)) begin
                    window[g*PIX_W +: PIX_W] = ordered[(o+g)*PIX_W +: PIX_W];
                end
            end
        end
    end
endmodule

// File: rtl/sad_lane.sv
module sad_lane #(
    parameter int PIX_W  = 8,
    parameter int HALF_W = 16
) (
    input  logic [PIX_W-1:0]  pix_a,
    input  logic [PIX_W-1:0]  pix_b,
    input  logic [HALF_W-1:0] base,
    input  logic              en,
    output logic [HALF_W-1:0] result
);
    logic [PIX_W-1:0]  diff;
    logic [HALF_W:0]   total;

    assign diff  = (pix_a > pix_b) ? (pix_a - pix_b) : (pix_b - pix_a);
    assign total = {1'b0, base} + {{(HALF_W+1-PIX_W){1'b0}}, diff};

    always_comb begin
        if (!en) begin
            result = base;
        end else if (total[HALF_W]) begin
            result = '1;
        end else begin
            result = total[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
    parameter int PIX_W  = 8,
    parameter int HALF_W = 16,
    parameter int SUM_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [8*PIX_W-1:0]     pair_a,
    input  logic [8*PIX_W-1:0]     pair_b,
    input  logic [1:0]             off_a,
    input  logic [1:0]             off_b,
    input  logic                   swap_a,
    input  logic                   swap_b,
    input  logic                   valid,
    input  logic                   clear,
    input  logic                   reduce,
    output logic [SUM_W-1:0]       sum_upper,
    output logic [SUM_W-1:0]       sum_lower
);
    import sad_pkg::*;

    localparam int WIN_W = LANES * PIX_W;
    localparam int ACC_W = LANES * HALF_W;

    sad_state_t state_q, state_d;

    logic [WIN_W-1:0] win_a, win_b;
    logic [ACC_W-1:0] half_q;
    logic [ACC_W-1:0] acc_view;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] acc_next;
    logic [SUM_W-1:0] upper_d, lower_d;

    sad_align #(.PIX_W(PIX_W)) u_align_a (
        .pair(pair_a), .offset(off_a), .swap(swap_a), .window(win_a)
    );
    sad_align #(.PIX_W(PIX_W)) u_align_b (
        .pair(pair_b), .offset(off_b), .swap(swap_b), .window(win_b)
    );

    // Empty state reads as zero without rewriting storage.
    assign acc_view = (state_q == ST_EMPTY) ? '0 : half_q;
    assign base     = clear ? '0 : acc_view;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sad_lane #(.PIX_W(PIX_W), .HALF_W(HALF_W)) u_lane (
            .pix_a (win_a[g*PIX_W +: PIX_W]),
            .pix_b (win_b[g*PIX_W +: PIX_W]),
            .base  (base[g*HALF_W +: HALF_W]),
            .en    (valid),
            .result(acc_next[g*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (valid) state_d = ST_LIVE;
            ST_LIVE:  if (clear && !valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            half_q  <= '0;
        end else begin
            state_q <= state_d;
            if (valid) begin
                half_q <= acc_next;
            end
        end
    end

    assign lower_d = {{(SUM_W-HALF_W){1'b0}}, acc_next[0*HALF_W +: HALF_W]}
                   + {{(SUM_W-HALF_W){1'b0}}, acc_next[1*HALF_W +: HALF_W]};
    assign upper_d = {{(SUM_W-HALF_W){1'b0}}, acc_next[2*HALF_W +: HALF_W]}
                   + {{(SUM_W-HALF_W){1'b0}}, acc_next[3*HALF_W +: HALF_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_upper <= '0;
            sum_lower <= '0;
        end else if (reduce) begin
            sum_upper <= upper_d;
            sum_lower <= lower_d;
        end
    end
endmodule

// File: rtl/sad_accum_chk.sv
module sad_accum_chk #(
    parameter int HALF_W = 16,
    parameter int SUM_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid,
    input logic                clear,
    input logic                reduce,
    input logic [4*HALF_W-1:0] acc_view,
    input logic [SUM_W-1:0]    sum_upper,
    input logic [SUM_W-1:0]    sum_lower
);
    localparam int PAD = SUM_W - HALF_W;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (sum_upper == '0 && sum_lower == '0 && acc_view == '0));

    assert_hold_totals_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reduce |=> ($stable(sum_upper) && $stable(sum_lower)));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clear) |=> $stable(acc_view));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !valid) |=> (acc_view == '0));

    assert_no_wrap_l0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (acc_view[0*HALF_W +: HALF_W] >= $past(acc_view[0*HALF_W +: HALF_W])));
    assert_no_wrap_l1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (acc_view[1*HALF_W +: HALF_W] >= $past(acc_view[1*HALF_W +: HALF_W])));
    assert_no_wrap_l2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (acc_view[2*HALF_W +: HALF_W] >= $past(acc_view[2*HALF_W +: HALF_W])));
    assert_no_wrap_l3_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (acc_view[3*HALF_W +: HALF_W] >= $past(acc_view[3*HALF_W +: HALF_W])));

    assert_reduce_fold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reduce |=> (sum_upper == {{PAD{1'b0}}, acc_view[2*HALF_W +: HALF_W]}
                               + {{PAD{1'b0}}, acc_view[3*HALF_W +: HALF_W]}
                 && sum_lower == {{PAD{1'b0}}, acc_view[0*HALF_W +: HALF_W]}
                               + {{PAD{1'b0}}, acc_view[1*HALF_W +: HALF_W]}));
endmodule

bind sad_accum sad_accum_chk #(.HALF_W(HALF_W), .SUM_W(SUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid(valid), .clear(clear), .reduce(reduce),
    .acc_view(acc_view), .sum_upper(sum_upper), .sum_lower(sum_lower)
);

// File: tb/sad_accum_test.sv
`timescale 1ns/1ps
module sad_accum_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pair_a = '0, pair_b = '0;
    logic [1:0]  off_a = '0, off_b = '0;
    logic        swap_a = 1'b0, swap_b = 1'b0;
    logic        valid = 1'b0, clear = 1'b0, reduce = 1'b0;
    logic [31:0] sum_upper, sum_lower;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ref_half [4];
    longint ref_upper = 0, ref_lower = 0;

    always #2.5 clk = ~clk;

    sad_accum uut (
        .clk(clk), .rst_n(rst_n), .pair_a(pair_a), .pair_b(pair_b),
        .off_a(off_a), .off_b(off_b), .swap_a(swap_a), .swap_b(swap_b),
        .valid(valid), .clear(clear), .reduce(reduce),
        .sum_upper(sum_upper), .sum_lower(sum_lower)
    );

    function automatic int pick(input logic [63:0] p, input logic [1:0] o,
                                input logic s, input int lane);
        logic [63:0] w;
        w = s ? {p[31:0], p[63:32]} : p;
        return int'(w[8*(int'(o)+lane) +: 8]);
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (sum_upper !== 32'(ref_upper) || sum_lower !== 32'(ref_lower)) begin
            errors++;
            $display("FAIL %s upper act %h exp %h lower act %h exp %h",
                     tag, sum_upper, 32'(ref_upper), sum_lower, 32'(ref_lower));
        end
    endtask

    task automatic cyc(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] oa, input logic [1:0] ob,
                       input logic sa, input logic sb,
                       input logic v, input logic c, input logic r, input string tag);
        pair_a = a; pair_b = b; off_a = oa; off_b = ob;
        swap_a = sa; swap_b = sb; valid = v; clear = c; reduce = r;
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            int base, d;
            base = c ? 0 : ref_half[k];
            d = pick(a, oa, sa, k) - pick(b, ob, sb, k);
            if (d < 0) d = -d;
            if (v) begin
                base = base + d;
                if (base > 65535) base = 65535;
            end
            ref_half[k] = base;
        end
        if (r) begin
            ref_upper = longint'(ref_half[2]) + longint'(ref_half[3]);
            ref_lower = longint'(ref_half[0]) + longint'(ref_half[1]);
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) ref_half[k] = 0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        cyc('0, '0, 2'd0, 2'd0, 0, 0, 0, 0, 1, "R1 zero after reset");

        // Lane isolation: only byte 0 differs, then only byte 3
        cyc(64'h05, 64'h00, 2'd0, 2'd0, 0, 0, 1, 0, 1, "R4 lane0 to lower");
        cyc(64'h0900_0000, 64'h0, 2'd0, 2'd0, 0, 0, 1, 0, 1, "R4 lane3 to upper");
        cyc(64'h0000_0000_0010_0000, 64'h0000_0000_0013_0000, 2'd0, 2'd0, 0, 0, 1, 1, 1, "R7 clear with valid");

        // Offsets on a ramp pattern
        for (int o = 0; o < 4; o++)
            cyc(64'h0F0D_0B09_0705_0301, 64'h0E0C_0A08_0604_0200,
                2'(o), 2'(3-o), 0, 0, 1, (o == 0), 1, "R2 window offsets");
        cyc(64'h0F0D_0B09_0705_0301, 64'h0E0C_0A08_0604_0200, 2'd2, 2'd1, 1, 0, 1, 1, 1, "R3 swap a");
        cyc(64'h0F0D_0B09_0705_0301, 64'h0E0C_0A08_0604_0200, 2'd3, 2'd0, 0, 1, 1, 0, 1, "R3 swap b");

        // Hold checks
        cyc(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd1, 2'd2, 0, 0, 0, 0, 1, "R10 idle no change");
        cyc(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0, 2'd0, 0, 0, 1, 0, 0, "R9 totals hold");
        cyc('0, '0, 2'd0, 2'd0, 0, 0, 0, 0, 1, "R8 folded after update");

        // Clear alone
        cyc(64'h1234, 64'h0, 2'd0, 2'd0, 0, 0, 0, 1, 0, "R6 clear no reduce");
        cyc('0, '0, 2'd0, 2'd0, 0, 0, 0, 0, 1, "R6 cleared totals");

        // Saturation
        for (int n = 0; n < 260; n++)
            cyc(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0, 2'd0, 0, 0, 1, 0, (n % 50 == 0), "R5 saturate");
        cyc('0, '0, 2'd0, 2'd0, 0, 0, 0, 0, 1, "R5 saturated totals");

        // Mixed traffic
        for (int n = 0; n < 400; n++)
            cyc({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom % 4 != 0), 1'($urandom % 16 == 0),
                1'($urandom), "R8 mixed");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule